// File: doc/BRIEF.md
# Address Translation Cache Front-End

This block turns every logical address presented on its request port into a physical address, a set of attribute bits and a result flag. Two programmable window registers match high-order address bits and hand an address through unchanged, with the attributes of that window. Failing a window match, and while paged translation is on, an eight-entry fully associative cache of page translations supplies the physical page number. A lookup that misses raises a miss flag, which asks an external table walker to fetch the translation and write it in through the entry-load port.

Reset and an asynchronous disable pin both turn paged translation off. Neither of them discards cached entries, and reset leaves the page size alone. While the pin is held, the windows still match, flushes still clear the cache, and probe lookups still search it. An access that goes untranslated gets all-zero attributes. Software is expected to flush the cache after reset and before it sets the enable bit.

Top module: `atc_front`

## Requirements
- R1: Synchronous reset clears the control enable bit (bit 0) and the enable bit of every window. A following request returns pa equal to la, attr 0, and hit, miss and fault all low.
- R2: Reset changes neither the page-size bit nor any cached entry. After reset a probe still hits with the page size that was set before it.
- R3: A flush clears every cache entry, including while the control enable bit is clear. A flush and a load in the same cycle leave the cache empty.
- R4: A request accepted on one clock edge shows its result on the next edge with rsp_valid high. rsp_valid is low out of reset.
- R5: Window w is written with reg_sel = w+1. Its fields are base in [31:24], mask in [23:16], enable in [15] and attr in [3:0]. An enabled window matches when la[31:24] and base agree on every bit whose mask bit is 0. A match returns pa = la, that window's attr and hit. It wins over the cache, window 0 wins over window 1, and matching does not depend on the control enable bit or the disable pin.
- R6: The control register is written with reg_sel = 0. With its enable bit set, a cache entry hits when it is valid, its supervisor bit equals req_sup, and its tag matches. The result is pa = {ppn, page offset}, the entry's attr and hit.
- R7: With translation active and no window or cache match, the block raises miss and returns pa = la with attr 0.
- R8: Control bit 1 selects the page size: 0 gives 4 KiB pages (offset la[11:0]) and 1 gives 8 KiB pages (offset la[12:0], tag bit 12 and ppn bit 12 ignored).
- R9: A write to a cached page with its write-protect bit set raises fault, returns the entry's pa and attr, and raises neither hit nor miss. A read of that page, or a write to an unprotected page, is a hit.
- R10: The disable pin passes through two synchronizing flops and is sampled when a request is accepted. A request accepted three or more cycles after the pin changes follows the new level. While the pin is asserted, non-probe requests skip the cache, pass la through with attr 0 and never raise miss.
- R11: A probe request (req_probe) searches the windows and the cache whatever the state of the enable bit and the disable pin, and reports hit, miss or fault.
- R12: Loads fill entries in round-robin order. After a flush and nine loads, the first page loaded is gone and the other eight still hit.
- R13: At most one of hit, miss and fault is set. When neither hit nor fault is set, attr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_off | input | 1 | Asynchronous translation-disable pin |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, w+1 window w |
| reg_wdata | input | 32 | Register write data |
| flush | input | 1 | Invalidate all cache entries |
| ld_valid | input | 1 | Load one translation entry |
| ld_la | input | 32 | Logical address of the loaded page |
| ld_pa | input | 32 | Physical address of the loaded page |
| ld_sup | input | 1 | Loaded entry belongs to supervisor space |
| ld_wp | input | 1 | Loaded entry is write-protected |
| ld_attr | input | 4 | Attribute bits of the loaded entry |
| req_valid | input | 1 | Request strobe |
| req_la | input | 32 | Logical address |
| req_wr | input | 1 | Request is a write |
| req_sup | input | 1 | Request is in supervisor space |
| req_probe | input | 1 | Probe lookup, ignores enable and disable pin |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_pa | output | 32 | Physical address |
| rsp_attr | output | 4 | Attribute bits |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Table search requested |
| rsp_fault | output | 1 | Write to a write-protected page |

## Verification
The assertions assume that software flushes the cache after reset and before it sets the enable bit or loads entries, because the valid bits have no reset value of their own. They also assume that loads never put two matching entries for one page into the cache. The stimulus flushes right after the first reset and loads only distinct pages. It changes the disable pin only between requests and waits three cycles before the next request, so every request sees a settled synchronizer output. It never drives a register write or a load together with reset.

// File: rtl/atc_pkg.sv
package atc_pkg;
    parameter int LA_W     = 32;
    parameter int PG_SHIFT = 12;
    parameter int ATTR_W   = 4;
    parameter int WIN_BITS = 8;
    parameter int REG_W    = 32;
    localparam int TAG_W   = LA_W - PG_SHIFT;

    typedef struct packed {
        logic en;
        logic pg8;
    } ctl_t;

    typedef struct packed {
        logic                en;
        logic [WIN_BITS-1:0] base;
        logic [WIN_BITS-1:0] mask;
        logic [ATTR_W-1:0]   attr;
    } win_t;

    typedef struct packed {
        logic              valid;
        logic              sup;
        logic              wp;
        logic [ATTR_W-1:0] attr;
        logic [TAG_W-1:0]  tag;
        logic [TAG_W-1:0]  ppn;
    } ent_t;

    typedef struct packed {
        logic [LA_W-1:0]   pa;
        logic [ATTR_W-1:0] attr;
        logic              hit;
        logic              miss;
        logic              fault;
    } rsp_t;

    function automatic win_t unpack_win(input logic [REG_W-1:0] d);
        win_t w;
        w.base = d[REG_W-1 -: WIN_BITS];
        w.mask = d[REG_W-WIN_BITS-1 -: WIN_BITS];
        w.en   = d[15];
        w.attr = d[ATTR_W-1:0];
        return w;
    endfunction

    function automatic logic tag_eq(input logic [TAG_W-1:0] a,
                                    input logic [TAG_W-1:0] b,
                                    input logic pg8);
        if (pg8) return a[TAG_W-1:1] == b[TAG_W-1:1];
        return a == b;
    endfunction

    function automatic logic [LA_W-1:0] join_pa(input logic [TAG_W-1:0] ppn,
                                                input logic [LA_W-1:0] la,
                                                input logic pg8);
        if (pg8) return {ppn[TAG_W-1:1], la[PG_SHIFT:0]};
        return {ppn, la[PG_SHIFT-1:0]};
    endfunction
endpackage

// File: rtl/atc_regs.sv
module atc_regs
    import atc_pkg::*;
#(
    parameter int N_WIN = 2,
    parameter int SEL_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_we,
    input  logic [SEL_W-1:0]       reg_sel,
    input  logic [REG_W-1:0]       reg_wdata,
    output ctl_t                   ctl,
    output win_t [N_WIN-1:0]       wins
);
    logic [N_WIN-1:0] win_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.en <= 1'b0;
            for (int w = 0; w < N_WIN; w++) wins[w].en <= 1'b0;
        end else if (reg_we) begin
            if (reg_sel == '0) begin
                ctl.en  <= reg_wdata[0];
                ctl.pg8 <= reg_wdata[1];
            end
            for (int w = 0; w < N_WIN; w++)
                if (int'(reg_sel) == w + 1) wins[w] <= unpack_win(reg_wdata);
        end
    end

    always_comb
        for (int w = 0; w < N_WIN; w++) win_en[w] = wins[w].en;

    // R1
    rst_off_chk: assert property (@(posedge clk) rst |=> (!ctl.en && win_en == '0));
    // R2
    pgsize_keep_chk: assert property (@(posedge clk) rst |=> $stable(ctl.pg8));
endmodule

// File: rtl/atc_window.sv
module atc_window
    import atc_pkg::*;
#(
    parameter int N_WIN = 2
) (
    input  logic [LA_W-1:0]     la,
    input  win_t [N_WIN-1:0]    wins,
    output logic                hit,
    output logic [ATTR_W-1:0]   attr
);
    logic [N_WIN-1:0] match;

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        assign match[g] = wins[g].en &&
            (((la[LA_W-1 -: WIN_BITS] ^ wins[g].base) & ~wins[g].mask) == '0);
    end

    always_comb begin
        hit  = |match;
        attr = '0;
        for (int w = N_WIN - 1; w >= 0; w--)
            if (match[w]) attr = wins[w].attr;
    end
endmodule

// File: rtl/atc_cache.sv
module atc_cache
    import atc_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               ld_valid,
    input  logic [LA_W-1:0]    ld_la,
    input  logic [LA_W-1:0]    ld_pa,
    input  logic               ld_sup,
    input  logic               ld_wp,
    input  logic [ATTR_W-1:0]  ld_attr,
    input  logic [LA_W-1:0]    lk_la,
    input  logic               lk_sup,
    input  logic               pg8,
    output logic               found,
    output logic [TAG_W-1:0]   ppn,
    output logic               wp,
    output logic [ATTR_W-1:0]  attr
);
    localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    ent_t             ents [N_ENT];
    logic [PTR_W-1:0] ptr;
    logic [N_ENT-1:0] valid_vec;
    logic [N_ENT-1:0] hit_vec;
    ent_t             new_ent;

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.sup   = ld_sup;
        new_ent.wp    = ld_wp;
        new_ent.attr  = ld_attr;
        new_ent.tag   = ld_la[LA_W-1:PG_SHIFT];
        new_ent.ppn   = ld_pa[LA_W-1:PG_SHIFT];
    end

    // entries carry no reset: a reset must leave cached translations in place
    always_ff @(posedge clk) begin
        if (flush) begin
            for (int i = 0; i < N_ENT; i++) ents[i].valid <= 1'b0;
        end else if (ld_valid) begin
            ents[ptr] <= new_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else if (ld_valid && !flush)
            ptr <= (int'(ptr) == N_ENT - 1) ? '0 : ptr + 1'b1;
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign valid_vec[g] = ents[g].valid;
        assign hit_vec[g]   = ents[g].valid && (ents[g].sup == lk_sup) &&
                              tag_eq(ents[g].tag, lk_la[LA_W-1:PG_SHIFT], pg8);
    end

    always_comb begin
        found = |hit_vec;
        ppn   = '0;
        wp    = 1'b0;
        attr  = '0;
        for (int i = N_ENT - 1; i >= 0; i--)
            if (hit_vec[i]) begin
                ppn  = ents[i].ppn;
                wp   = ents[i].wp;
                attr = ents[i].attr;
            end
    end

    // R3
    flush_clear_chk: assert property (@(posedge clk) flush |=> valid_vec == '0);
    // R12
    load_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !flush) |=> valid_vec[$past(ptr)]);
endmodule

// File: rtl/atc_front.sv
module atc_front
    import atc_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int N_WIN = 2,
    parameter int SEL_W = $clog2(N_WIN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               xlat_off,
    input  logic               reg_we,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic               flush,
    input  logic               ld_valid,
    input  logic [LA_W-1:0]    ld_la,
    input  logic [LA_W-1:0]    ld_pa,
    input  logic               ld_sup,
    input  logic               ld_wp,
    input  logic [ATTR_W-1:0]  ld_attr,
    input  logic               req_valid,
    input  logic [LA_W-1:0]    req_la,
    input  logic               req_wr,
    input  logic               req_sup,
    input  logic               req_probe,
    output logic               rsp_valid,
    output logic [LA_W-1:0]    rsp_pa,
    output logic [ATTR_W-1:0]  rsp_attr,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic               rsp_fault
);
    ctl_t              ctl;
    win_t [N_WIN-1:0]  wins;
    logic              w_hit;
    logic [ATTR_W-1:0] w_attr;
    logic              c_found;
    logic [TAG_W-1:0]  c_ppn;
    logic              c_wp;
    logic [ATTR_W-1:0] c_attr;
    logic              off_q1, off_q2;
    logic              active;
    rsp_t              nxt, rsp_q;

    atc_regs #(.N_WIN(N_WIN), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctl(ctl), .wins(wins)
    );

    atc_window #(.N_WIN(N_WIN)) u_win (
        .la(req_la), .wins(wins), .hit(w_hit), .attr(w_attr)
    );

    atc_cache #(.N_ENT(N_ENT)) u_cache (
        .clk(clk), .rst(rst), .flush(flush), .ld_valid(ld_valid),
        .ld_la(ld_la), .ld_pa(ld_pa), .ld_sup(ld_sup), .ld_wp(ld_wp),
        .ld_attr(ld_attr), .lk_la(req_la), .lk_sup(req_sup), .pg8(ctl.pg8),
        .found(c_found), .ppn(c_ppn), .wp(c_wp), .attr(c_attr)
    );

    // two-flop synchronizer; its output is sampled at each accepted request
    always_ff @(posedge clk) begin
        if (rst) begin
            off_q1 <= 1'b0;
            off_q2 <= 1'b0;
        end else begin
            off_q1 <= xlat_off;
            off_q2 <= off_q1;
        end
    end

    always_comb begin
        active  = req_probe || (ctl.en && !off_q2);
        nxt     = '0;
        nxt.pa  = req_la;
        if (w_hit) begin
            nxt.attr = w_attr;
            nxt.hit  = 1'b1;
        end else if (active) begin
            if (c_found) begin
                nxt.pa   = join_pa(c_ppn, req_la, ctl.pg8);
                nxt.attr = c_attr;
                if (req_wr && c_wp) nxt.fault = 1'b1;
                else                nxt.hit   = 1'b1;
            end else begin
                nxt.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) rsp_q <= nxt;
        end
    end

    assign rsp_pa    = rsp_q.pa;
    assign rsp_attr  = rsp_q.attr;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_fault = rsp_q.fault;

    // R4
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R13
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_hit, rsp_miss, rsp_fault}));
    // R13
    attr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit && !rsp_fault) |-> rsp_attr == '0);
    // R10
    off_nomiss_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_probe && off_q2) |=> !rsp_miss);
    // R9
    fault_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_wr) |=> !rsp_fault);
endmodule

// File: tb/sim_atc_front.sv
module sim_atc_front;
    localparam int CLK_NS = 20;

    typedef struct packed {
        logic [31:0] la;
        logic        wr;
        logic        sup;
        logic [31:0] pa;
        logic [3:0]  attr;
        logic        hit;
        logic        miss;
        logic        fault;
        logic [7:0]  rq;
    } vec_t;

    // translation on, 4 KiB pages, windows 0 and 1 programmed
    localparam vec_t VECS [8] = '{
        '{32'h0001_0123, 1'b0, 1'b0, 32'h0ABC_D123, 4'h5, 1'b1, 1'b0, 1'b0, 8'd6},  // R6
        '{32'h0002_0456, 1'b0, 1'b1, 32'h0DEF_0456, 4'hA, 1'b1, 1'b0, 1'b0, 8'd6},  // R6
        '{32'h0002_0456, 1'b1, 1'b1, 32'h0DEF_0456, 4'hA, 1'b0, 1'b0, 1'b1, 8'd9},  // R9
        '{32'h0002_0456, 1'b0, 1'b0, 32'h0002_0456, 4'h0, 1'b0, 1'b1, 1'b0, 8'd7},  // R7
        '{32'h0001_1123, 1'b0, 1'b0, 32'h0001_1123, 4'h0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8
        '{32'hF000_1234, 1'b0, 1'b0, 32'hF000_1234, 4'h3, 1'b1, 1'b0, 1'b0, 8'd5},  // R5
        '{32'hF500_1234, 1'b1, 1'b1, 32'hF500_1234, 4'h6, 1'b1, 1'b0, 1'b0, 8'd5},  // R5
        '{32'h0001_0123, 1'b1, 1'b0, 32'h0ABC_D123, 4'h5, 1'b1, 1'b0, 1'b0, 8'd9}   // R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xlat_off = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        flush = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_la = '0;
    logic [31:0] ld_pa = '0;
    logic        ld_sup = 1'b0;
    logic        ld_wp = 1'b0;
    logic [3:0]  ld_attr = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_la = '0;
    logic        req_wr = 1'b0;
    logic        req_sup = 1'b0;
    logic        req_probe = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [3:0]  rsp_attr;
    logic        rsp_hit, rsp_miss, rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    atc_front u0 (
        .clk(clk), .rst(rst), .xlat_off(xlat_off), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .flush(flush),
        .ld_valid(ld_valid), .ld_la(ld_la), .ld_pa(ld_pa), .ld_sup(ld_sup),
        .ld_wp(ld_wp), .ld_attr(ld_attr), .req_valid(req_valid),
        .req_la(req_la), .req_wr(req_wr), .req_sup(req_sup),
        .req_probe(req_probe), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_attr(rsp_attr), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault)
    );

    task automatic chk(input string rq, input logic [31:0] pa_e, input logic [3:0] attr_e,
                       input logic hit_e, input logic miss_e, input logic fault_e);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_pa !== pa_e || rsp_attr !== attr_e ||
            rsp_hit !== hit_e || rsp_miss !== miss_e || rsp_fault !== fault_e) begin
            errors++;
            $display("FAIL %s: v=%b pa=%h attr=%h h=%b m=%b f=%b expected v=1 pa=%h attr=%h h=%b m=%b f=%b",
                     rq, rsp_valid, rsp_pa, rsp_attr, rsp_hit, rsp_miss, rsp_fault,
                     pa_e, attr_e, hit_e, miss_e, fault_e);
        end
    endtask

    task automatic req(input logic [31:0] la, input logic wr, input logic sup, input logic probe);
        req_valid = 1'b1; req_la = la; req_wr = wr; req_sup = sup; req_probe = probe;
        @(negedge clk);
        req_valid = 1'b0; req_probe = 1'b0; req_wr = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic load(input logic [31:0] la, input logic [31:0] pa, input logic sup,
                        input logic wp, input logic [3:0] attr, input logic with_flush);
        ld_valid = 1'b1; ld_la = la; ld_pa = pa; ld_sup = sup; ld_wp = wp; ld_attr = attr;
        flush = with_flush;
        @(negedge clk);
        ld_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4: no result out of reset
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R4: rsp_valid=%b expected 0", rsp_valid);
        end
        // R1: pass-through after reset
        req(32'h1234_5678, 1'b0, 1'b0, 1'b0);
        chk("R1", 32'h1234_5678, 4'h0, 1'b0, 1'b0, 1'b0);

        do_flush();
        load(32'h0001_0000, 32'h0ABC_D000, 1'b0, 1'b0, 4'h5, 1'b0);
        load(32'h0002_0000, 32'h0DEF_0000, 1'b1, 1'b1, 4'hA, 1'b0);
        wreg(2'd1, 32'hF000_8003);
        wreg(2'd2, 32'hF00F_8006);
        // R5: window hit with the enable bit still clear
        req(32'hF000_1234, 1'b0, 1'b0, 1'b0);
        chk("R5", 32'hF000_1234, 4'h3, 1'b1, 1'b0, 1'b0);
        wreg(2'd0, 32'h0000_0001);

        for (int i = 0; i < 8; i++) begin
            req(VECS[i].la, VECS[i].wr, VECS[i].sup, 1'b0);
            chk($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].pa, VECS[i].attr,
                VECS[i].hit, VECS[i].miss, VECS[i].fault);
        end

        // R8: 8 KiB pages
        wreg(2'd0, 32'h0000_0003);
        req(32'h0001_1123, 1'b0, 1'b0, 1'b0);
        chk("R8", 32'h0ABC_D123, 4'h5, 1'b1, 1'b0, 1'b0);
        req(32'h0001_0123, 1'b0, 1'b0, 1'b0);
        chk("R8", 32'h0ABC_C123, 4'h5, 1'b1, 1'b0, 1'b0);
        wreg(2'd0, 32'h0000_0001);

        // R10: disable pin
        xlat_off = 1'b1;
        repeat (3) @(negedge clk);
        req(32'h0001_0123, 1'b0, 1'b0, 1'b0);
        chk("R10", 32'h0001_0123, 4'h0, 1'b0, 1'b0, 1'b0);
        req(32'h0003_0000, 1'b0, 1'b0, 1'b0);
        chk("R10", 32'h0003_0000, 4'h0, 1'b0, 1'b0, 1'b0);
        req(32'hF000_1234, 1'b0, 1'b0, 1'b0);
        chk("R5", 32'hF000_1234, 4'h3, 1'b1, 1'b0, 1'b0);
        // R11: probe ignores the pin
        req(32'h0001_0123, 1'b0, 1'b0, 1'b1);
        chk("R11", 32'h0ABC_D123, 4'h5, 1'b1, 1'b0, 1'b0);
        req(32'h0003_0000, 1'b0, 1'b0, 1'b1);
        chk("R11", 32'h0003_0000, 4'h0, 1'b0, 1'b1, 1'b0);
        xlat_off = 1'b0;
        repeat (3) @(negedge clk);
        req(32'h0001_0123, 1'b0, 1'b0, 1'b0);
        chk("R10", 32'h0ABC_D123, 4'h5, 1'b1, 1'b0, 1'b0);

        // R1 and R2 across a reset taken with 8 KiB pages on
        wreg(2'd0, 32'h0000_0003);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        req(32'h0001_0123, 1'b0, 1'b0, 1'b0);
        chk("R1", 32'h0001_0123, 4'h0, 1'b0, 1'b0, 1'b0);
        req(32'hF000_1234, 1'b0, 1'b0, 1'b0);
        chk("R1", 32'hF000_1234, 4'h0, 1'b0, 1'b0, 1'b0);
        req(32'h0001_1123, 1'b0, 1'b0, 1'b1);
        chk("R2", 32'h0ABC_D123, 4'h5, 1'b1, 1'b0, 1'b0);

        // R3: flush with enable clear, then flush beating a load
        do_flush();
        req(32'h0001_0123, 1'b0, 1'b0, 1'b1);
        chk("R3", 32'h0001_0123, 4'h0, 1'b0, 1'b1, 1'b0);
        load(32'h0001_0000, 32'h0ABC_D000, 1'b0, 1'b0, 4'h5, 1'b1);
        req(32'h0001_0123, 1'b0, 1'b0, 1'b1);
        chk("R3", 32'h0001_0123, 4'h0, 1'b0, 1'b1, 1'b0);

        // R12: round-robin replacement
        wreg(2'd0, 32'h0000_0001);
        do_flush();
        for (int i = 0; i < 9; i++)
            load(32'h0010_0000 + (i << 12), 32'h0020_0000 + (i << 12), 1'b0, 1'b0,
                 4'(i), 1'b0);
        req(32'h0010_0000, 1'b0, 1'b0, 1'b1);
        chk("R12", 32'h0010_0000, 4'h0, 1'b0, 1'b1, 1'b0);
        req(32'h0010_1000, 1'b0, 1'b0, 1'b1);
        chk("R12", 32'h0020_1000, 4'h1, 1'b1, 1'b0, 1'b0);
        req(32'h0010_8ABC, 1'b0, 1'b0, 1'b1);
        chk("R12", 32'h0020_8ABC, 4'h8, 1'b1, 1'b0, 1'b0);

        finish_run();
    end
endmodule